// File: doc/BRIEF.md
# Half-Rate Clock Generator with Wait-State Acknowledge

This block divides a fast input clock by two to give a system clock. The output has an even duty cycle whatever the input duty cycle is, because it comes from a single toggle flop. The same block answers a bus controller's accesses with an active-low transfer acknowledge. That acknowledge arrives one divided-clock period later than it otherwise would, so every access gets exactly one wait state.

A request is present when the register chip-select strobe is low, when the DMA acknowledge input is low, or when both are low. The request is sampled only at falling edges of the divided clock. The samples move through a short shift register, and the acknowledge is low while the newest `DEPTH` samples are all active.

The design uses one clock. Each falling edge of the divided clock is the rising edge of the fast clock on which the divider leaves its high state. All state resets asynchronously.

Top module: `clk_wait_gen`

## Requirements
- R1: `clk_half` inverts on every rising edge of `clk_in` while out of reset, so it is `clk_in` divided by two with a duty cycle of exactly one fast period high and one low.
- R2: While `rst_n` is low, `clk_half` is 0, `ack_n` is 1 and the sample history is cleared. The first rising edge of `clk_in` after release drives `clk_half` to 1.
- R3: The request is active when `cs_n` is 0 or `dma_ack_n` is 0. It is sampled only on the rising edges of `clk_in` where `clk_half` goes from 1 to 0.
- R4: With `DEPTH`=2, `ack_n` goes low on the sampling edge that follows the first edge that samples the request active. This gives exactly one wait state.
- R5: `ack_n` returns high on the first sampling edge that samples the request inactive.
- R6: A request pulse that starts and ends between two sampling edges never drives `ack_n` low.
- R7: `ack_n` changes only on falling edges of `clk_half`.
- R8: A request made only through `dma_ack_n`, with `cs_n` held high, produces the same acknowledge timing as one made through `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| cs_n | input | 1 | Active-low register chip-select strobe |
| dma_ack_n | input | 1 | Active-low DMA acknowledge request |
| clk_half | output | 1 | Divided-by-two clock |
| ack_n | output | 1 | Active-low transfer acknowledge |

## Verification
The bench builds the block with `DEPTH`=2, the one-wait-state setting. It sweeps three request sources (strobe only, DMA only, both), both divider phases at the start of a request, and request lengths from one to eight fast cycles. This covers pulses that no sampling edge sees, pulses that exactly one sampling edge sees, and pulses long enough to reach the acknowledge. A reset applied in the middle of an acknowledge confirms that the divider and the history both clear.

// File: rtl/clk_wait_gen.sv
module clk_wait_gen #(
  parameter int DEPTH = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic cs_n,
  input  logic dma_ack_n,
  output logic clk_half,
  output logic ack_n
);

  logic             req;
  logic             fall;
  logic [DEPTH-1:0] hist;

  assign req  = ~cs_n | ~dma_ack_n;
  assign fall = clk_half;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) clk_half <= 1'b0;
    else        clk_half <= ~clk_half;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)    hist <= '0;
    else if (fall) hist <= {hist[DEPTH-2:0], req};
  end

  assign ack_n = ~&hist;

  p_toggle_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
    1'b1 |=> clk_half != $past(clk_half));

  p_reset_r2: assert property (@(posedge clk_in)
    !rst_n |-> (!clk_half && ack_n));

  p_assert_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (fall && req && (&hist[DEPTH-2:0])) |=> !ack_n);

  p_release_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (fall && !req) |=> ack_n);

  p_edge_only_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ack_n != $past(ack_n)) |-> $past(clk_half));

endmodule

// File: tb/clk_wait_gen_bench.sv
module clk_wait_gen_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 2;

  logic clk_in = 1'b0;
  logic rst_n = 1'b1;
  logic cs_n = 1'b1;
  logic dma_ack_n = 1'b1;
  logic clk_half, ack_n;

  int n_tests = 0;
  int n_fail  = 0;

  clk_wait_gen #(.DEPTH(DEPTH)) u_clk_wait_gen (
    .clk_in(clk_in), .rst_n(rst_n), .cs_n(cs_n), .dma_ack_n(dma_ack_n),
    .clk_half(clk_half), .ack_n(ack_n)
  );

  always #(CLK_P/2) clk_in = ~clk_in;

  int edges;
  int run;
  always @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      edges <= 0;
      run   <= 0;
    end else begin
      edges <= edges + 1;
      if (edges % 2 == 1) begin
        if (!cs_n || !dma_ack_n) run <= (run < DEPTH) ? run + 1 : DEPTH;
        else                     run <= 0;
      end
    end
  end

  logic exp_half, exp_ack_n;
  assign exp_half  = (edges % 2) == 1;
  assign exp_ack_n = !(run >= DEPTH);

  int   obs_low, exp_low;
  logic prev_half, prev_ack;
  logic have_prev = 1'b0;

  always @(negedge clk_in) begin
    if (rst_n) begin
      n_tests++;
      if (clk_half !== exp_half) begin
        n_fail++;
        $display("FAIL R1 clk_half actual=%b expected=%b", clk_half, exp_half);
      end
      n_tests++;
      if (ack_n !== exp_ack_n) begin
        n_fail++;
        $display("FAIL %s ack_n actual=%b expected=%b",
                 exp_ack_n ? "R5" : "R4", ack_n, exp_ack_n);
      end
      if (have_prev && ack_n !== prev_ack) begin
        n_tests++;
        if (!(prev_half === 1'b1 && clk_half === 1'b0)) begin
          n_fail++;
          $display("FAIL R7 ack_n changed off edge actual_half=%b expected=0", clk_half);
        end
      end
      if (!ack_n) obs_low++;
      if (!exp_ack_n) exp_low++;
      prev_half = clk_half;
      prev_ack  = ack_n;
      have_prev = 1'b1;
    end else begin
      have_prev = 1'b0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    #(CLK_P * 3);
    chk("R2 clk_half in reset", clk_half, 1'b0);
    chk("R2 ack_n in reset", ack_n, 1'b1);
    @(negedge clk_in) rst_n = 1'b1;
    @(negedge clk_in);
    chk("R2 first edge after release", clk_half, 1'b1);

    for (int src = 0; src < 3; src++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int len = 1; len <= 8; len++) begin
          @(negedge clk_in);
          while (clk_half !== ph[0]) @(negedge clk_in);
          @(posedge clk_in); #1;
          obs_low = 0; exp_low = 0;
          @(negedge clk_in);
          cs_n      = (src == 1);
          dma_ack_n = (src == 0);
          repeat (len) @(negedge clk_in);
          cs_n = 1'b1; dma_ack_n = 1'b1;
          repeat (8) @(negedge clk_in);
          @(posedge clk_in); #1;
          n_tests++;
          if (obs_low != exp_low) begin
            n_fail++;
            $display("FAIL %s low cycles src=%0d ph=%0d len=%0d actual=%0d expected=%0d",
                     src == 1 ? "R8" : "R3", src, ph, len, obs_low, exp_low);
          end
          if (len == 1) begin
            n_tests++;
            if (ph == 0 && obs_low != 0) begin
              n_fail++;
              $display("FAIL R6 short pulse acknowledged actual=%0d expected=0", obs_low);
            end
          end
          if (len == 8) begin
            n_tests++;
            if (obs_low == 0) begin
              n_fail++;
              $display("FAIL %s long request unacknowledged actual=0 expected>0",
                       src == 1 ? "R8" : "R4");
            end
          end
        end
      end
    end

    @(negedge clk_in) cs_n = 1'b0;
    repeat (8) @(negedge clk_in);
    chk("R4 held request acknowledged", ack_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R2 mid-run reset ack_n", ack_n, 1'b1);
    chk("R2 mid-run reset clk_half", clk_half, 1'b0);
    @(negedge clk_in) cs_n = 1'b1;
    rst_n = 1'b1;
    repeat (6) @(negedge clk_in);
    chk("R2 no stale acknowledge", ack_n, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule